// File: doc/BRIEF.md
# Operating Mode Decoder and Segment Shadow Loader

This block tracks the operating mode of a processor core with a segmented memory model. Each cycle it samples the protection-enable bit, the paging-enable bit, the long-mode enable request, the virtual-8086 flag and the long bit of the current code segment. From these it registers an effective long-mode-active bit and one of five modes: real, protected, virtual-8086, compatibility and 64-bit.

Segment selector loads arrive with the descriptor fields already fetched. The block then updates one of six shadow entries. Each entry holds a selector, a base, a limit and a default-size bit. How a load is handled depends on the mode. In some modes the selector value builds the entry directly. In others the descriptor fields are copied, after a privilege comparison against the current privilege level. The block also grants or refuses direct programmed I/O requests. It forms the linear address of an effective address, with a limit check that follows the rules of the current mode.

Top module: `mode_seg_ctrl`

## Requirements
- R1: `lma` is a register that follows `lme_req AND cr_pg` one clock after those inputs are sampled. No other path writes it. It is 0 after reset.
- R2: `mode` is registered one clock after its inputs, with codes 0 real, 1 protected, 2 virtual-8086, 3 compatibility and 4 64-bit. When long mode is active, the code is 4 if the stored code-segment long bit is 1 and 3 otherwise. Otherwise the code is 0 if `cr_pe` is 0, 2 if `fl_vm` is 1, and 1 in all remaining cases. The stored long bit changes only on a code-segment load in modes 1, 3 or 4.
- R3: Segment indices are 0 ES, 1 CS, 2 SS, 3 DS, 4 FS and 5 GS. In modes 0 and 2, a load writes base = selector shifted left by 4, limit = 0xFFFF and size = 0 (16 bit). No descriptor field is used and no fault is raised.
- R4: In modes 1 and 3, a load copies the descriptor base, limit and size only when descriptor DPL >= CPL. A load of CS also copies the DPL as the new code DPL and copies the descriptor long bit. When DPL < CPL, `ld_fault` pulses for one cycle and the entry stays unchanged.
- R5: In mode 4, a load is never refused. The descriptor fields are copied as in R4, and `ld_fault` stays 0.
- R6: While long mode is active, `fl_vm` has no influence on `mode`.
- R7: CPL is 0 in mode 0 and 3 in mode 2. In every other mode it is the stored code DPL. One cycle after `io_valid`, exactly one of `io_ok` and `io_fault` pulses: `io_ok` when `fl_iopl` >= CPL, and `io_fault` otherwise.
- R8: After reset, all six entries hold selector 0, base 0, limit 0xFFFF and size 0. CPL is 0, the mode is real and no pulse output is set.
- R9: In mode 4, `ea_lin` = base + offset for FS and GS, and `ea_lin` = offset for the other segments, with `ea_oob` = 0. In all other modes, `ea_lin` = base + offset and `ea_oob` = (offset > limit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_pe | input | 1 | Protection-enable control bit |
| cr_pg | input | 1 | Paging-enable control bit |
| lme_req | input | 1 | Long-mode enable request |
| fl_vm | input | 1 | Virtual-8086 flag |
| fl_iopl | input | 2 | I/O privilege level field of the flags |
| ld_valid | input | 1 | Selector load request |
| ld_seg | input | 3 | Segment index of the load |
| ld_sel | input | 16 | Selector value being loaded |
| desc_base | input | 32 | Fetched descriptor base |
| desc_limit | input | 32 | Fetched descriptor limit |
| desc_dpl | input | 2 | Fetched descriptor privilege level |
| desc_big | input | 1 | Fetched descriptor default size (1 = 32 bit) |
| desc_long | input | 1 | Fetched descriptor long bit |
| io_valid | input | 1 | Direct I/O access request |
| rd_seg | input | 3 | Segment index for the shadow read port |
| ea_seg | input | 3 | Segment index for address formation |
| ea_off | input | 32 | Offset for address formation |
| mode | output | 3 | Registered mode code |
| lma | output | 1 | Effective long-mode-active bit |
| cpl | output | 2 | Current privilege level |
| ld_fault | output | 1 | One-cycle pulse on a refused load |
| io_ok | output | 1 | One-cycle pulse on a granted I/O access |
| io_fault | output | 1 | One-cycle pulse on a refused I/O access |
| rd_sel | output | 16 | Selector of the read entry |
| rd_base | output | 32 | Base of the read entry |
| rd_limit | output | 32 | Limit of the read entry |
| rd_big | output | 1 | Default size of the read entry |
| ea_lin | output | 32 | Linear address |
| ea_oob | output | 1 | Offset beyond the segment limit |

## Verification
Selector loads are tried in every mode with random selectors and descriptor fields. Comparing the read-back entries shows whether the selector-derived path or the descriptor path was taken, and whether a refused load left the entry unchanged. Code-segment loads with random DPLs push CPL up and down, so loads and I/O requests hit both sides of the privilege comparison, including the equal case. The control bits are switched in all combinations, including the virtual-8086 flag set while long mode is active, which separates the five-way mode decode priorities. Effective addresses through every segment, with offsets on both sides of the limit, distinguish the FS/GS base path in 64-bit mode from the zero-base path.

// File: rtl/mseg_pkg.sv
package mseg_pkg;

    typedef enum logic [2:0] {
        MODE_REAL   = 3'd0,
        MODE_PROT   = 3'd1,
        MODE_V86    = 3'd2,
        MODE_COMPAT = 3'd3,
        MODE_LONG64 = 3'd4
    } cpu_mode_e;

    localparam int SEG_IDX_CS = 1;
    localparam int SEG_IDX_FS = 4;
    localparam int SEG_IDX_GS = 5;

endpackage

// File: rtl/mseg_mode_dec.sv
module mseg_mode_dec
    import mseg_pkg::*;
(
    input  logic      pe_i,
    input  logic      pg_i,
    input  logic      lme_i,
    input  logic      vm_i,
    input  logic      cs_long_i,
    output logic      lma_o,
    output cpu_mode_e mode_o
);
    always_comb begin
        lma_o = lme_i & pg_i;
        if (lma_o) begin
            mode_o = cs_long_i ? MODE_LONG64 : MODE_COMPAT;
        end else if (!pe_i) begin
            mode_o = MODE_REAL;
        end else if (vm_i) begin
            mode_o = MODE_V86;
        end else begin
            mode_o = MODE_PROT;
        end
    end
endmodule

// File: rtl/mseg_priv_chk.sv
module mseg_priv_chk #(
    parameter int PL_W = 2
) (
    input  logic [PL_W-1:0] granted_pl_i,
    input  logic [PL_W-1:0] cur_pl_i,
    output logic            allow_o
);
    assign allow_o = (granted_pl_i >= cur_pl_i);
endmodule

// File: rtl/mseg_ea_unit.sv
module mseg_ea_unit
    import mseg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  cpu_mode_e         mode_i,
    input  logic              base_used_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] limit_i,
    input  logic [ADDR_W-1:0] off_i,
    output logic [ADDR_W-1:0] lin_o,
    output logic              oob_o
);
    always_comb begin
        if (mode_i == MODE_LONG64) begin
            lin_o = base_used_i ? (base_i + off_i) : off_i;
            oob_o = 1'b0;
        end else begin
            lin_o = base_i + off_i;
            oob_o = (off_i > limit_i);
        end
    end
endmodule

// File: rtl/mode_seg_ctrl.sv
module mode_seg_ctrl
    import mseg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16,
    parameter int NSEG   = 6,
    parameter int IDX_W  = 3,
    parameter int PL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cr_pe,
    input  logic              cr_pg,
    input  logic              lme_req,
    input  logic              fl_vm,
    input  logic [PL_W-1:0]   fl_iopl,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_seg,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [ADDR_W-1:0] desc_limit,
    input  logic [PL_W-1:0]   desc_dpl,
    input  logic              desc_big,
    input  logic              desc_long,
    input  logic              io_valid,
    input  logic [IDX_W-1:0]  rd_seg,
    input  logic [IDX_W-1:0]  ea_seg,
    input  logic [ADDR_W-1:0] ea_off,
    output logic [2:0]        mode,
    output logic              lma,
    output logic [PL_W-1:0]   cpl,
    output logic              ld_fault,
    output logic              io_ok,
    output logic              io_fault,
    output logic [SEL_W-1:0]  rd_sel,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W-1:0] rd_limit,
    output logic              rd_big,
    output logic [ADDR_W-1:0] ea_lin,
    output logic              ea_oob
);
    localparam int PAD_W = ADDR_W - SEL_W - 4;
    localparam logic [ADDR_W-1:0] RM_LIMIT = ADDR_W'(16'hFFFF);
    localparam logic [PL_W-1:0]   PL_MAX   = {PL_W{1'b1}};

    typedef struct packed {
        logic [NSEG-1:0][SEL_W-1:0]  sel;
        logic [NSEG-1:0][ADDR_W-1:0] base;
        logic [NSEG-1:0][ADDR_W-1:0] limit;
        logic [NSEG-1:0]             big;
        logic [PL_W-1:0]             cs_dpl;
        logic                        cs_long;
        cpu_mode_e                   mode;
        logic                        lma;
        logic                        ld_fault;
        logic                        io_ok;
        logic                        io_fault;
    } state_t;

    state_t st_q, st_d;

    logic      lma_next;
    cpu_mode_e mode_next;
    logic [PL_W-1:0] cpl_cur;
    logic      ld_allow;
    logic      io_allow;

    mseg_mode_dec u_mode_dec (
        .pe_i      (cr_pe),
        .pg_i      (cr_pg),
        .lme_i     (lme_req),
        .vm_i      (fl_vm),
        .cs_long_i (st_q.cs_long),
        .lma_o     (lma_next),
        .mode_o    (mode_next)
    );

    always_comb begin
        case (st_q.mode)
            MODE_REAL: cpl_cur = '0;
            MODE_V86:  cpl_cur = PL_MAX;
            default:   cpl_cur = st_q.cs_dpl;
        endcase
    end

    mseg_priv_chk #(.PL_W(PL_W)) u_ld_chk (
        .granted_pl_i (desc_dpl),
        .cur_pl_i     (cpl_cur),
        .allow_o      (ld_allow)
    );

    mseg_priv_chk #(.PL_W(PL_W)) u_io_chk (
        .granted_pl_i (fl_iopl),
        .cur_pl_i     (cpl_cur),
        .allow_o      (io_allow)
    );

    // Next-state computation
    always_comb begin
        logic seg_ok;
        logic sel_mode;
        logic chk_mode;
        int   idx;
        st_d          = st_q;
        st_d.mode     = mode_next;
        st_d.lma      = lma_next;
        st_d.ld_fault = 1'b0;
        st_d.io_ok    = io_valid & io_allow;
        st_d.io_fault = io_valid & ~io_allow;

        seg_ok   = (int'(ld_seg) < NSEG);
        idx      = seg_ok ? int'(ld_seg) : 0;
        sel_mode = (st_q.mode == MODE_REAL) || (st_q.mode == MODE_V86);
        chk_mode = (st_q.mode == MODE_PROT) || (st_q.mode == MODE_COMPAT);

        if (ld_valid && seg_ok) begin
            if (sel_mode) begin
                st_d.sel[idx]   = ld_sel;
                st_d.base[idx]  = {{PAD_W{1'b0}}, ld_sel, 4'b0000};
                st_d.limit[idx] = RM_LIMIT;
                st_d.big[idx]   = 1'b0;
            end else if (chk_mode && !ld_allow) begin
                st_d.ld_fault = 1'b1;
            end else begin
                st_d.sel[idx]   = ld_sel;
                st_d.base[idx]  = desc_base;
                st_d.limit[idx] = desc_limit;
                st_d.big[idx]   = desc_big;
                if (idx == SEG_IDX_CS) begin
                    st_d.cs_dpl  = desc_dpl;
                    st_d.cs_long = desc_long;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) begin
                st_q.sel[i]   <= '0;
                st_q.base[i]  <= '0;
                st_q.limit[i] <= RM_LIMIT;
                st_q.big[i]   <= 1'b0;
            end
            st_q.cs_dpl   <= '0;
            st_q.cs_long  <= 1'b0;
            st_q.mode     <= MODE_REAL;
            st_q.lma      <= 1'b0;
            st_q.ld_fault <= 1'b0;
            st_q.io_ok    <= 1'b0;
            st_q.io_fault <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read port and address formation
    logic [ADDR_W-1:0] ea_base, ea_limit;
    logic              ea_fsgs;

    always_comb begin
        int ri;
        int ei;
        ri = (int'(rd_seg) < NSEG) ? int'(rd_seg) : 0;
        ei = (int'(ea_seg) < NSEG) ? int'(ea_seg) : 0;
        rd_sel   = st_q.sel[ri];
        rd_base  = st_q.base[ri];
        rd_limit = st_q.limit[ri];
        rd_big   = st_q.big[ri];
        ea_base  = st_q.base[ei];
        ea_limit = st_q.limit[ei];
        ea_fsgs  = (ei == SEG_IDX_FS) || (ei == SEG_IDX_GS);
    end

    mseg_ea_unit #(.ADDR_W(ADDR_W)) u_ea (
        .mode_i      (st_q.mode),
        .base_used_i (ea_fsgs),
        .base_i      (ea_base),
        .limit_i     (ea_limit),
        .off_i       (ea_off),
        .lin_o       (ea_lin),
        .oob_o       (ea_oob)
    );

    assign mode     = st_q.mode;
    assign lma      = st_q.lma;
    assign cpl      = cpl_cur;
    assign ld_fault = st_q.ld_fault;
    assign io_ok    = st_q.io_ok;
    assign io_fault = st_q.io_fault;

endmodule

// File: rtl/mseg_checker.sv
module mseg_checker #(
    parameter int PL_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lme_req,
    input logic            cr_pg,
    input logic            ld_valid,
    input logic [PL_W-1:0] desc_dpl,
    input logic            io_valid,
    input logic [2:0]      mode,
    input logic            lma,
    input logic [PL_W-1:0] cpl,
    input logic            ld_fault,
    input logic            io_ok,
    input logic            io_fault
);
    AST_LMA_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lma == $past(lme_req & cr_pg))); // R1
    AST_MODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode <= 3'd4); // R2
    AST_NOLMA_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
        !lma |-> (mode < 3'd3)); // R2
    AST_LMA_SUBMODE: assert property (@(posedge clk) disable iff (!rst_n)
        lma |-> (mode >= 3'd3)); // R6
    AST_LD_SELMODE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (mode == 3'd0 || mode == 3'd2)) |=> !ld_fault); // R3
    AST_LD_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (mode == 3'd1 || mode == 3'd3) && (desc_dpl < cpl)) |=> ld_fault); // R4
    AST_FAULT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !ld_fault); // R4
    AST_LD_LONG_NOCHK: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && mode == 3'd4) |=> !ld_fault); // R5
    AST_REAL_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |-> (cpl == '0)); // R7
    AST_IO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_ok && io_fault)); // R7
    AST_IO_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |=> (io_ok || io_fault)); // R7
endmodule

bind mode_seg_ctrl mseg_checker #(.PL_W(PL_W)) u_mseg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .lme_req  (lme_req),
    .cr_pg    (cr_pg),
    .ld_valid (ld_valid),
    .desc_dpl (desc_dpl),
    .io_valid (io_valid),
    .mode     (mode),
    .lma      (lma),
    .cpl      (cpl),
    .ld_fault (ld_fault),
    .io_ok    (io_ok),
    .io_fault (io_fault)
);

// File: tb/mode_seg_ctrl_bench.sv
module mode_seg_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCYC       = 4000;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cr_pe = 0, cr_pg = 0, lme_req = 0, fl_vm = 0;
    logic [1:0]  fl_iopl = 0;
    logic        ld_valid = 0;
    logic [2:0]  ld_seg = 0;
    logic [15:0] ld_sel = 0;
    logic [31:0] desc_base = 0, desc_limit = 0;
    logic [1:0]  desc_dpl = 0;
    logic        desc_big = 0, desc_long = 0, io_valid = 0;
    logic [2:0]  rd_seg = 0, ea_seg = 0;
    logic [31:0] ea_off = 0;
    logic [2:0]  mode;
    logic        lma;
    logic [1:0]  cpl;
    logic        ld_fault, io_ok, io_fault;
    logic [15:0] rd_sel;
    logic [31:0] rd_base, rd_limit;
    logic        rd_big;
    logic [31:0] ea_lin;
    logic        ea_oob;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_seg_ctrl u_mode_seg_ctrl (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    logic [15:0] m_sel[6];
    logic [31:0] m_base[6], m_limit[6];
    logic        m_big[6];
    logic [1:0]  m_csdpl;
    logic        m_cslong, m_lma, m_ldf, m_iook, m_iof;
    logic [2:0]  m_mode;

    function automatic logic [2:0] f_mode(logic pe, logic pg, logic lme, logic vm, logic csl);
        if (lme && pg) return csl ? 3'd4 : 3'd3;
        if (!pe) return 3'd0;
        if (vm) return 3'd2;
        return 3'd1;
    endfunction

    function automatic logic [1:0] f_cpl(logic [2:0] md, logic [1:0] d);
        if (md == 3'd0) return 2'd0;
        if (md == 3'd2) return 2'd3;
        return d;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 6; i++) begin
            m_sel[i] = 0; m_base[i] = 0; m_limit[i] = 32'hFFFF; m_big[i] = 0;
        end
        m_csdpl = 0; m_cslong = 0; m_lma = 0; m_ldf = 0; m_iook = 0; m_iof = 0;
        m_mode = 3'd0;
    endtask

    task automatic model_step();
        logic [1:0] c;
        logic [2:0] nm;
        int i;
        c  = f_cpl(m_mode, m_csdpl);
        nm = f_mode(cr_pe, cr_pg, lme_req, fl_vm, m_cslong);
        m_ldf  = 0;
        m_iook = io_valid && (fl_iopl >= c);
        m_iof  = io_valid && (fl_iopl < c);
        if (ld_valid && ld_seg < 6) begin
            i = int'(ld_seg);
            if (m_mode == 0 || m_mode == 2) begin
                m_sel[i] = ld_sel; m_base[i] = {12'd0, ld_sel, 4'd0};
                m_limit[i] = 32'hFFFF; m_big[i] = 0;
            end else if ((m_mode == 1 || m_mode == 3) && desc_dpl < c) begin
                m_ldf = 1;
            end else begin
                m_sel[i] = ld_sel; m_base[i] = desc_base;
                m_limit[i] = desc_limit; m_big[i] = desc_big;
                if (i == 1) begin m_csdpl = desc_dpl; m_cslong = desc_long; end
            end
        end
        m_lma  = lme_req & cr_pg;
        m_mode = nm;
    endtask

    task automatic check_all(string rdreq);
        int r, e;
        logic [31:0] xl;
        logic xo;
        r = int'(rd_seg); e = int'(ea_seg);
        chk("R1", "lma", 32'(lma), 32'(m_lma));
        chk(m_lma ? "R6" : "R2", "mode", 32'(mode), 32'(m_mode));
        chk("R7", "cpl", 32'(cpl), 32'(f_cpl(m_mode, m_csdpl)));
        chk("R7", "io_ok", 32'(io_ok), 32'(m_iook));
        chk("R7", "io_fault", 32'(io_fault), 32'(m_iof));
        chk("R4", "ld_fault", 32'(ld_fault), 32'(m_ldf));
        chk(rdreq, "rd_sel", 32'(rd_sel), 32'(m_sel[r]));
        chk(rdreq, "rd_base", rd_base, m_base[r]);
        chk(rdreq, "rd_limit", rd_limit, m_limit[r]);
        chk(rdreq, "rd_big", 32'(rd_big), 32'(m_big[r]));
        if (m_mode == 3'd4) begin
            xl = (e == 4 || e == 5) ? m_base[e] + ea_off : ea_off;
            xo = 0;
        end else begin
            xl = m_base[e] + ea_off;
            xo = ea_off > m_limit[e];
        end
        chk("R9", "ea_lin", ea_lin, xl);
        chk("R9", "ea_oob", 32'(ea_oob), 32'(xo));
    endtask

    task automatic step(string rdreq);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(rdreq);
    endtask

    task automatic idle();
        ld_valid = 0; io_valid = 0;
    endtask

    task automatic do_load(logic [2:0] s, logic [15:0] sel, logic [31:0] b,
                           logic [31:0] l, logic [1:0] d, logic bg, logic lg, string req);
        ld_valid = 1; ld_seg = s; ld_sel = sel; desc_base = b; desc_limit = l;
        desc_dpl = d; desc_big = bg; desc_long = lg; rd_seg = s; ea_seg = s;
        step(req);
        idle();
    endtask

    task automatic set_ctrl(logic pe, logic pg, logic lme, logic vm, string req);
        cr_pe = pe; cr_pg = pg; lme_req = lme; fl_vm = vm;
        step(req);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'h5EED_0042);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state of every entry
        for (int i = 0; i < 6; i++) begin
            rd_seg = 3'(i); ea_seg = 3'(i); ea_off = 32'h10000;
            #1; check_all("R8");
        end
        // R3: real-mode load builds base from selector
        do_load(3'd3, 16'h1234, 32'hDEAD_0000, 32'h5, 2'd3, 1'b1, 1'b0, "R3");
        chk("R3", "real base", rd_base, 32'h0001_2340);
        step("R3");
        // R7: I/O in real mode always granted
        fl_iopl = 0; io_valid = 1; step("R7"); idle();
        // protected mode, CS dpl 0 then raise CPL to 3
        set_ctrl(1, 0, 0, 0, "R2");
        do_load(3'd1, 16'h0008, 32'h0, 32'hFFFF_FFFF, 2'd3, 1'b1, 1'b0, "R4");
        // R4: dpl 2 < cpl 3 refused, entry unchanged
        do_load(3'd2, 16'h0010, 32'h1000, 32'h2000, 2'd2, 1'b1, 1'b0, "R4");
        chk("R4", "denied base", rd_base, 32'h0);
        fl_iopl = 2; io_valid = 1; step("R7"); idle();
        // v86 via flag, CPL 3
        set_ctrl(1, 0, 0, 1, "R2");
        do_load(3'd0, 16'hFFFF, 32'h1, 32'h1, 2'd0, 1'b1, 1'b0, "R3");
        chk("R3", "v86 base", rd_base, 32'h000F_FFF0);
        // long mode, flag set but ignored -> compatibility
        set_ctrl(1, 1, 1, 1, "R6");
        step("R6");
        // CS load with long bit, dpl 3 >= cpl 3
        do_load(3'd1, 16'h0033, 32'h0, 32'h0, 2'd3, 1'b0, 1'b1, "R4");
        step("R2");
        // R5: 64-bit, dpl 0 < cpl 3 still loads
        do_load(3'd5, 16'h002B, 32'h7000_0000, 32'h10, 2'd0, 1'b0, 1'b0, "R5");
        chk("R5", "gs base", rd_base, 32'h7000_0000);
        ea_seg = 3'd5; ea_off = 32'h100; #1;
        chk("R9", "gs lin", ea_lin, 32'h7000_0100);
        ea_seg = 3'd2; ea_off = 32'hFFFF_0000; #1;
        chk("R9", "ss no limit", 32'(ea_oob), 32'd0);

        // random phase
        for (int n = 0; n < NCYC; n++) begin
            if ($urandom_range(15) == 0) begin
                cr_pe = 1'($urandom); cr_pg = 1'($urandom);
                lme_req = 1'($urandom); fl_vm = 1'($urandom);
            end
            fl_iopl    = 2'($urandom);
            ld_valid   = 1'($urandom);
            ld_seg     = 3'($urandom_range(5));
            ld_sel     = 16'($urandom);
            desc_base  = $urandom;
            desc_limit = $urandom_range(1) ? 32'($urandom_range(65535)) : $urandom;
            desc_dpl   = 2'($urandom);
            desc_big   = 1'($urandom);
            desc_long  = 1'($urandom);
            io_valid   = 1'($urandom);
            rd_seg     = 3'($urandom_range(5));
            ea_seg     = 3'($urandom_range(5));
            ea_off     = $urandom_range(1) ? 32'($urandom_range(131071)) : $urandom;
            step((m_mode == 0 || m_mode == 2) ? "R3" : (m_mode == 4 ? "R5" : "R4"));
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule